// File: doc/BRIEF.md
# Page-Buffered Non-Volatile Array Write Controller

This block is the control logic in front of a byte-wide non-volatile array. A host drives active-low chip-select, write-strobe and read-strobe lines as if they were pins. A system clock samples these lines. Each accepted write strobe loads one byte into a 64-entry page buffer. After the strobes have been idle for a set number of cycles, the buffered bytes are committed to the array in a single internal program cycle. Every timing window is a parameter counted in clock cycles. The array is an ordinary synchronous RAM with 2**ADDR_W bytes. The default is kept small; set ADDR_W to 13 for the full 8 K organisation.

The address splits in two. The upper bits (ADDR_W-1 down to 6) select a page, and the six low bits pick a byte within it. The first byte of a burst fixes the page, and each later byte in the burst supplies only its offset. While the block is loading or programming it holds `busy` high and refuses reads. It also ignores new bursts until the program cycle ends. A low level on `inhibit_n` blocks reads, discards the burst and aborts a program cycle that is under way.

Host inputs pass a two-stage synchronizer, so every effect appears at least two clock cycles after a pin changes. The block has no valid/ready handshake and applies no back-pressure: a host obeys `busy`, or its writes are dropped.

Top module: `eeprom_page_writer`

## Requirements
- R1: A byte load is accepted only when `ce_n` and `we_n` are low and `oe_n` is high for at least FILT_CYC consecutive synchronized samples. A shorter pulse changes nothing and leaves `busy` low.
- R2: The load address is taken when the write condition first becomes true, which is at the later of the two falling strobes. The load data is taken when the condition ends, which is at the first rising strobe.
- R3: The page field (address bits ADDR_W-1..6) is latched from the first load of a burst and is held for the whole burst. Each later load contributes only its bits 5..0 as the byte offset.
- R4: A load is dropped if its falling edge comes more than LOAD_WIN cycles after the previous accepted falling edge of the same burst.
- R5: Programming starts on its own after the strobes have been idle for IDLE_CYC cycles following the last accepted data byte. Only the offsets loaded in the burst change in the array.
- R6: If one offset is loaded more than once in a burst, the value loaded last is the one written.
- R7: `busy` rises with the first accepted load and stays high for at least IDLE_CYC+PROG_CYC cycles until the commit ends. Loads presented while programming are ignored.
- R8: A read (`ce_n` and `oe_n` low, `we_n` high) while the block is idle and `inhibit_n` is high sets `rd_valid` to 1 and puts the addressed array byte on `rdata` three cycles after the pins change. Otherwise `rd_valid` is 0 and `rdata` is 0.
- R9: While `inhibit_n` is low, reads are refused and `busy` returns low. An open burst or a program cycle under way is dropped, and the array keeps its old contents if the abort comes before the copy phase.
- R10: After reset, `busy` and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control logic |
| inhibit_n | input | 1 | Active-low protect line; low blocks reads and programming |
| ce_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low read strobe |
| addr | input | ADDR_W | Byte address: page in the upper bits, offset in bits 5..0 |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, zero when no read is served |
| rd_valid | output | 1 | High while a read is being served |
| busy | output | 1 | High from the first accepted load until the commit ends |

## Verification
The hardest situations to reach from the ports depend on where the internal timers stand. One is a load that arrives after the byte window has closed while the burst is still open. Another is an inhibit pulse that lands inside the program phase rather than in the load or copy phase. The bench reaches both by spacing its strobe tasks with gaps computed from the window parameters. One gap is longer than LOAD_WIN but shorter than IDLE_CYC. The other wait lets the idle timeout expire before the inhibit pulse, so the pulse falls within PROG_CYC. The bench then reads the array back to confirm which bytes survived.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2,
    ST_COPY = 2'd3
  } wr_state_e;
endpackage

// File: rtl/eepw_sync.sv
module eepw_sync #(
  parameter int           W      = 1,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar s = 0; s < STAGES; s++) begin : g_st
    logic [W-1:0] q;
    if (s == 0) begin : g_in
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= INIT;
        else        q <= din;
      end
    end else begin : g_mid
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= INIT;
        else        q <= g_st[s-1].q;
      end
    end
  end

  assign dout = g_st[STAGES-1].q;
endmodule

// File: rtl/eepw_strobe.sv
module eepw_strobe #(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int FILT_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ld_start,
  output logic [ADDR_W-1:0] ld_addr,
  output logic              ld_end,
  output logic [DATA_W-1:0] ld_data,
  output logic              wr_low,
  output logic              rd_cond
);
  localparam int RUN_W = $clog2(FILT_CYC + 1);

  logic              cond, cond_q, act;
  logic [RUN_W-1:0]  run;
  logic [ADDR_W-1:0] hold;

  assign cond    = ~ce_n & ~we_n & oe_n;
  assign rd_cond = ~ce_n & ~oe_n & we_n;
  assign wr_low  = cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q   <= 1'b0;
      act      <= 1'b0;
      run      <= '0;
      hold     <= '0;
      ld_start <= 1'b0;
      ld_end   <= 1'b0;
      ld_addr  <= '0;
      ld_data  <= '0;
    end else begin
      cond_q   <= cond;
      ld_start <= 1'b0;
      ld_end   <= 1'b0;
      // address frozen at the sample where both strobes are first low
      if (cond && !cond_q) hold <= addr;
      if (!cond) begin
        run <= '0;
        act <= 1'b0;
        if (act) begin
          ld_end  <= 1'b1;
          ld_data <= wdata;
        end
      end else if (!act) begin
        if (run == RUN_W'(FILT_CYC - 1)) begin
          act      <= 1'b1;
          ld_start <= 1'b1;
          ld_addr  <= cond_q ? hold : addr;
        end
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/eepw_page_buf.sv
module eepw_page_buf #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld
);
  localparam int SLOTS = 1 << OFF_W;

  logic [DATA_W-1:0] slot [SLOTS];
  logic [SLOTS-1:0]  vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < SLOTS; i++) slot[i] <= '0;
    end else if (clr) begin
      vld <= '0;
    end else if (wr_en) begin
      slot[wr_off] <= wr_data;
      vld[wr_off]  <= 1'b1;
    end
  end

  assign rd_data = slot[rd_off];
  assign rd_vld  = vld[rd_off];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eepw_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int OFF_W       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 3,
  parameter int LOAD_WIN    = 30,
  parameter int IDLE_CYC    = 100,
  parameter int PROG_CYC    = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inhibit_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              busy
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int PAGE_W  = ADDR_W - OFF_W;
  localparam int MAX_AB  = (LOAD_WIN > IDLE_CYC) ? LOAD_WIN : IDLE_CYC;
  localparam int TMR_MAX = (MAX_AB > PROG_CYC) ? MAX_AB : PROG_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 2);

  // synchronized pins
  logic [3:0]               ctl_s;
  logic [ADDR_W+DATA_W-1:0] bus_s;
  logic                     inh_s, ce_s, we_s, oe_s;
  logic [ADDR_W-1:0]        addr_s;
  logic [DATA_W-1:0]        wdata_s;

  eepw_sync #(.W(4), .STAGES(SYNC_STAGES), .INIT(4'b0111)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .din({inhibit_n, ce_n, we_n, oe_n}), .dout(ctl_s)
  );
  eepw_sync #(.W(ADDR_W + DATA_W), .STAGES(SYNC_STAGES), .INIT('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .din({addr, wdata}), .dout(bus_s)
  );

  assign {inh_s, ce_s, we_s, oe_s} = ctl_s;
  assign {addr_s, wdata_s}         = bus_s;

  // strobe decode
  logic              ld_start, ld_end, wr_low, rd_cond;
  logic [ADDR_W-1:0] ld_addr;
  logic [DATA_W-1:0] ld_data;

  eepw_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILT_CYC(FILT_CYC)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_s), .we_n(we_s), .oe_n(oe_s),
    .addr(addr_s), .wdata(wdata_s),
    .ld_start(ld_start), .ld_addr(ld_addr), .ld_end(ld_end), .ld_data(ld_data),
    .wr_low(wr_low), .rd_cond(rd_cond)
  );

  // control state
  wr_state_e         state;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q, cp_idx;
  logic              pend;
  logic [TMR_W-1:0]  fall_cnt, idle_cnt, prog_cnt;

  logic              buf_wr, buf_clr, buf_vld, mem_we;
  logic [DATA_W-1:0] buf_data;
  logic [ADDR_W-1:0] mem_addr;

  assign buf_wr   = (state == ST_LOAD) && inh_s && pend && ld_end;
  assign buf_clr  = (state == ST_IDLE);
  assign mem_we   = (state == ST_COPY) && inh_s && buf_vld;
  assign mem_addr = {page_q, cp_idx};
  assign busy     = (state != ST_IDLE);

  eepw_page_buf #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr),
    .wr_off(off_q), .wr_data(ld_data), .rd_off(cp_idx),
    .rd_data(buf_data), .rd_vld(buf_vld)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      page_q   <= '0;
      off_q    <= '0;
      cp_idx   <= '0;
      pend     <= 1'b0;
      fall_cnt <= '0;
      idle_cnt <= '0;
      prog_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ld_start && inh_s) begin
            page_q   <= ld_addr[ADDR_W-1:OFF_W];
            off_q    <= ld_addr[OFF_W-1:0];
            pend     <= 1'b1;
            fall_cnt <= '0;
            idle_cnt <= '0;
            state    <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (!inh_s) begin
            pend  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            if (fall_cnt != {TMR_W{1'b1}}) fall_cnt <= fall_cnt + 1'b1;
            if (ld_start) begin
              if (fall_cnt < TMR_W'(LOAD_WIN)) begin
                off_q    <= ld_addr[OFF_W-1:0];
                pend     <= 1'b1;
                fall_cnt <= '0;
              end
            end else if (ld_end && pend) begin
              pend     <= 1'b0;
              idle_cnt <= '0;
            end else if (!pend && !wr_low) begin
              if (idle_cnt == TMR_W'(IDLE_CYC - 1)) begin
                prog_cnt <= '0;
                state    <= ST_PROG;
              end else begin
                idle_cnt <= idle_cnt + 1'b1;
              end
            end
          end
        end
        ST_PROG: begin
          if (!inh_s) begin
            state <= ST_IDLE;
          end else if (prog_cnt == TMR_W'(PROG_CYC - 1)) begin
            cp_idx <= '0;
            state  <= ST_COPY;
          end else begin
            prog_cnt <= prog_cnt + 1'b1;
          end
        end
        default: begin
          if (!inh_s || cp_idx == {OFF_W{1'b1}}) state <= ST_IDLE;
          else                                   cp_idx <= cp_idx + 1'b1;
        end
      endcase
    end
  end

  // array
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= buf_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else if (rd_cond && inh_s && state == ST_IDLE) begin
      rd_valid <= 1'b1;
      rdata    <= mem[addr_s];
    end else begin
      rd_valid <= 1'b0;
      rdata    <= '0;
    end
  end
endmodule

// File: rtl/eepw_chk.sv
module eepw_chk
  import eepw_pkg::*;
#(
  parameter int PAGE_W   = 5,
  parameter int TMR_W    = 10,
  parameter int PROG_CYC = 500
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inh_s,
  input logic              rd_valid,
  input logic              mem_we,
  input wr_state_e         state,
  input logic [PAGE_W-1:0] page_q,
  input logic [TMR_W-1:0]  prog_cnt
);
  // R8
  rd_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(state) == ST_IDLE);

  // R9
  inhibit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inh_s |=> state == ST_IDLE);

  // R3
  page_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD && $past(state) == ST_LOAD) |-> $stable(page_q));

  // R7
  prog_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_PROG |-> prog_cnt < TMR_W'(PROG_CYC));

  // R5
  array_after_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(state) == ST_PROG || $past(state) == ST_COPY));

  // R7
  prog_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG && inh_s) |=> (state == ST_PROG || state == ST_COPY));
endmodule

bind eeprom_page_writer eepw_chk #(
  .PAGE_W(PAGE_W), .TMR_W(TMR_W), .PROG_CYC(PROG_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .inh_s(inh_s), .rd_valid(rd_valid),
  .mem_we(mem_we), .state(state), .page_q(page_q), .prog_cnt(prog_cnt)
);

// File: tb/tb_eeprom_page_writer.sv
module tb_eeprom_page_writer;
  localparam int AW    = 11;
  localparam int FILT  = 3;
  localparam int LWIN  = 30;
  localparam int IDLE  = 100;
  localparam int PROG  = 300;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inhibit_n = 1'b1;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          rd_valid, busy;

  int total = 0;
  int bad   = 0;
  int busy_len = 0;
  bit busy_d = 1'b0;
  bit smp_req = 1'b0;
  logic [8:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  eeprom_page_writer #(
    .ADDR_W(AW), .FILT_CYC(FILT), .LOAD_WIN(LWIN), .IDLE_CYC(IDLE), .PROG_CYC(PROG)
  ) dut (
    .clk(clk), .rst_n(rst_n), .inhibit_n(inhibit_n), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .busy(busy)
  );

  function automatic logic [7:0] base_val(input int off);
    return 8'(off * 3 + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // busy length monitor
  initial forever begin
    @(negedge clk);
    if (busy && !busy_d) busy_len = 1;
    else if (busy)       busy_len++;
    busy_d = busy;
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (smp_req) begin
      logic [8:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rd_valid == e[8] && rdata == (e[8] ? e[7:0] : 8'h00), t,
          {rd_valid, rdata}, {e[8], (e[8] ? e[7:0] : 8'h00)});
      smp_req = 1'b0;
    end
  end

  task automatic wr_byte(input logic [AW-1:0] a, input logic [7:0] d,
                         input int low_cyc, input int gap);
    @(negedge clk);
    addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
    repeat (low_cyc) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic rd_expect(input logic [AW-1:0] a, input logic [7:0] e,
                           input bit ev, input string t);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    repeat (5) @(negedge clk);
    exp_q.push_back({ev, e});
    tag_q.push_back(t);
    smp_req = 1'b1;
    while (smp_req) @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy == 1'b0, "R10 busy after reset", busy, 0);
    chk(rd_valid == 1'b0, "R10 rd_valid after reset", rd_valid, 0);

    // R5 R8: fill page 0
    for (int i = 0; i < 64; i++) begin
      wr_byte(AW'(i), base_val(i), 6, 4);
      if (i == 0) chk(busy == 1'b1, "R7 busy after first load", busy, 1);
    end
    wait_idle();
    rd_expect(AW'(0),  base_val(0),  1'b1, "R8 read off 0");
    rd_expect(AW'(17), base_val(17), 1'b1, "R5 read off 17");
    rd_expect(AW'(63), base_val(63), 1'b1, "R5 read off 63");

    // R5: partial page changes only loaded offsets
    wr_byte(AW'(5), 8'hA5, 6, 4);
    wr_byte(AW'(9), 8'hC9, 6, 4);
    wait_idle();
    rd_expect(AW'(5),  8'hA5,        1'b1, "R5 loaded off 5");
    rd_expect(AW'(9),  8'hC9,        1'b1, "R5 loaded off 9");
    rd_expect(AW'(4),  base_val(4),  1'b1, "R5 untouched off 4");
    rd_expect(AW'(6),  base_val(6),  1'b1, "R5 untouched off 6");

    // R6: same offset twice
    wr_byte(AW'(20), 8'h11, 6, 4);
    wr_byte(AW'(20), 8'h22, 6, 4);
    wait_idle();
    rd_expect(AW'(20), 8'h22, 1'b1, "R6 latest value kept");

    // R3: page frozen by first load; bits 5..0 give offset
    wr_byte(11'h080, 8'h5A, 6, 4);
    wr_byte(11'h7C3, 8'h3C, 6, 4);
    wait_idle();
    rd_expect(11'h080, 8'h5A, 1'b1, "R3 first byte page 2");
    rd_expect(11'h083, 8'h3C, 1'b1, "R3 second byte redirected to page 2");

    // R2: address at later fall, data at first rise
    @(negedge clk);
    addr = AW'(30); wdata = 8'h77; we_n = 1'b0;
    repeat (3) @(negedge clk);
    addr = AW'(31); ce_n = 1'b0;
    repeat (6) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    wdata = 8'h88;
    @(negedge clk);
    ce_n = 1'b1;
    repeat (4) @(negedge clk);
    wait_idle();
    rd_expect(AW'(31), 8'h77,        1'b1, "R2 addr at later fall, data at first rise");
    rd_expect(AW'(30), base_val(30), 1'b1, "R2 early address not used");

    // R1: short pulse filtered
    wr_byte(AW'(40), 8'hFF, 2, 20);
    chk(busy == 1'b0, "R1 short pulse leaves busy low", busy, 0);
    rd_expect(AW'(40), base_val(40), 1'b1, "R1 short pulse no write");

    // R4: late load dropped
    wr_byte(AW'(50), 8'h55, 6, 40);
    wr_byte(AW'(51), 8'h66, 6, 4);
    wait_idle();
    rd_expect(AW'(50), 8'h55,        1'b1, "R4 first load kept");
    rd_expect(AW'(51), base_val(51), 1'b1, "R4 late load dropped");

    // R7 R8: loads and reads during programming
    wr_byte(AW'(60), 8'h9A, 6, 4);
    repeat (IDLE + 50) @(negedge clk);
    wr_byte(AW'(61), 8'hEE, 6, 4);
    rd_expect(AW'(60), 8'h00, 1'b0, "R8 read refused while busy");
    wait_idle();
    chk(busy_len >= IDLE + PROG, "R7 busy duration", busy_len, IDLE + PROG);
    rd_expect(AW'(60), 8'h9A,        1'b1, "R7 committed byte");
    rd_expect(AW'(61), base_val(61), 1'b1, "R7 load during program ignored");

    // R9: inhibit aborts program, blocks reads
    wr_byte(AW'(62), 8'h12, 6, 4);
    repeat (IDLE + 50) @(negedge clk);
    inhibit_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(busy == 1'b0, "R9 busy drops on inhibit", busy, 0);
    rd_expect(AW'(62), 8'h00, 1'b0, "R9 read refused while inhibited");
    inhibit_n = 1'b1;
    repeat (5) @(negedge clk);
    rd_expect(AW'(62), base_val(62), 1'b1, "R9 aborted program leaves array");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule